// File: doc/BRIEF.md
# PWM Prescaler Clock Generator

This block turns one peripheral clock into a menu of timing enables for a group of PWM channels. A free-running binary prescaler supplies eleven power-of-two rates, from every cycle down to one cycle in 1024. Two independent linear dividers, A and B, each pick one of those prescaler rates and thin it further by a programmable integer from 1 to 255. The eleven prescaler rates plus the two divider outputs form a set of thirteen rates. Each of four channel selectors picks one of them for its own channel.

Every output is a single-cycle enable in the peripheral clock domain, never a derived clock, so the PWM counters downstream stay on one clock and simply advance when their enable is high. Configuration arrives on plain register inputs. A change to a divider's setting restarts that divider's count so the new ratio applies from a clean start.

Top module: `pwm_clock_menu`

## Requirements
- R1: Counting the first cycle after reset release as cycle t = 0, tapEn[k] (k = 0..10) is high in cycle t exactly when t mod 2^k equals 0; tapEn[0] is therefore high in every cycle out of reset.
- R2: With preA = p in 0..10 and divA = N in 1..255 held since reset, clkAEn is high exactly in those cycles where tapEn[p] is high and the number of tapEn[p] pulses since reset, this one included, is a multiple of N.
- R3: clkBEn follows the same rule using preB and divB, with no dependence on preA or divA.
- R4: A divider output is only ever high in a cycle where its selected prescaler tap is high, and with a ratio above 1 it is never high in two consecutive cycles.
- R5: A divide value of 0 disables that divider: its enable stays low.
- R6: A prescaler select value of 11 to 15 gives a divider no input, so its enable stays low.
- R7: If a divider's select or divide value differs from the previous cycle's, its output is low in that cycle and its count of tap pulses starts from zero in the following cycle.
- R8: Each 4-bit field chSel[4c+3:4c] drives chEn[c] from tapEn[value] for values 0 to 10, from clkAEn for 11, from clkBEn for 12, and holds it low for 13 to 15; channels are independent of one another.
- R9: While the synchronous active-high reset rst is high, every output is low, and the prescaler and both dividers restart from zero when it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| preA | input | 4 | Prescaler tap feeding divider A (0..10 valid) |
| divA | input | 8 | Divide ratio of divider A (0 = off) |
| preB | input | 4 | Prescaler tap feeding divider B (0..10 valid) |
| divB | input | 8 | Divide ratio of divider B (0 = off) |
| chSel | input | 16 | Four 4-bit rate selects, channel c at bits 4c+3:4c |
| tapEn | output | 11 | Prescaler enables, bit k at one cycle in 2^k |
| clkAEn | output | 1 | Divider A enable |
| clkBEn | output | 1 | Divider B enable |
| chEn | output | 4 | Selected enable for each channel |

## Verification
The assertions take for granted that configuration inputs are driven with defined values whenever reset is low, and that the ratio-bound and gap checks apply only in cycles where no restart is pending, since a change of ratio may momentarily leave the old count above the new limit. The stimulus applies every configuration while reset is held, so the first cycle out of reset never sees a restart, and changes a setting mid-run only at a falling edge so each change lasts a whole cycle. The sweeps cover every prescaler tap on divider A with ratios 0, 1 and 3 that later step up by one, divider B fed from each tap including invalid selects, a ratio of 255, and every channel select value.

// File: rtl/pwm_cg_pkg.sv
package pwm_cg_pkg;

  // number of linear dividers fed from the prescaler
  localparam int NUM_DIV = 2;

  // strobes from control to datapath, one bit per divider
  typedef struct packed {
    logic [NUM_DIV-1:0] restart;  // configuration changed this cycle
    logic [NUM_DIV-1:0] run;      // ratio non-zero and tap select valid
  } cgStrobes_t;

endpackage

// File: rtl/pwm_cg_ctrl.sv
module pwm_cg_ctrl
  import pwm_cg_pkg::*;
#(
  parameter int NUM_TAPS = 11,
  parameter int DIV_W    = 8,
  parameter int SEL_W    = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_DIV-1:0][SEL_W-1:0]   preCfg,
  input  logic [NUM_DIV-1:0][DIV_W-1:0]   divCfg,
  output cgStrobes_t                      stb
);

  logic [NUM_DIV-1:0][SEL_W-1:0] prevPre;
  logic [NUM_DIV-1:0][DIV_W-1:0] prevDiv;

  // shadow of the configuration; loaded during reset too, so the first
  // cycle after release never counts as a change
  always_ff @(posedge clk) begin
    prevPre <= preCfg;
    prevDiv <= divCfg;
  end

  for (genvar d = 0; d < NUM_DIV; d++) begin : gDivCtl
    always_comb begin
      stb.restart[d] = (preCfg[d] != prevPre[d]) || (divCfg[d] != prevDiv[d]);
      stb.run[d]     = (divCfg[d] != '0) && (int'(preCfg[d]) < NUM_TAPS);
    end

    assert_stable_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $stable(preCfg[d]) && $stable(divCfg[d])) |-> !stb.restart[d]);
  end

endmodule

// File: rtl/pwm_cg_lindiv.sv
module pwm_cg_lindiv #(
  parameter int NUM_TAPS = 11,
  parameter int DIV_W    = 8,
  parameter int SEL_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAPS-1:0] tapVec,
  input  logic [SEL_W-1:0]    pre,
  input  logic [DIV_W-1:0]    div,
  input  logic                restart,
  input  logic                run,
  output logic                pulse
);

  logic [DIV_W-1:0] divCnt;
  logic             tapSel;
  logic             hit;
  logic             atLast;

  always_comb begin
    tapSel = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (pre == SEL_W'(i)) tapSel = tapVec[i];
    end
  end

  assign hit    = run && !restart && tapSel;
  assign atLast = (divCnt == (div - DIV_W'(1)));
  assign pulse  = hit && atLast;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      divCnt <= '0;
    end else if (hit) begin
      divCnt <= atLast ? '0 : divCnt + DIV_W'(1);
    end
  end

  assert_off_when_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |-> !pulse);

  assert_gap_between_pulses_R4: assert property (@(posedge clk) disable iff (rst)
    (pulse && div > DIV_W'(1)) |=> !pulse);

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (divCnt == '0));

  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !restart) |-> (divCnt < div));

endmodule

// File: rtl/pwm_cg_chansel.sv
module pwm_cg_chansel #(
  parameter int NUM_TAPS = 11,
  parameter int SEL_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    sel,
  input  logic [NUM_TAPS-1:0] tapVec,
  input  logic                clkA,
  input  logic                clkB,
  output logic                en
);

  always_comb begin
    en = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (sel == SEL_W'(i)) en = tapVec[i];
    end
    if (sel == SEL_W'(NUM_TAPS))     en = clkA;
    if (sel == SEL_W'(NUM_TAPS + 1)) en = clkB;
  end

  assert_unused_sel_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (int'(sel) > NUM_TAPS + 1) |-> !en);

  assert_sel_a_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_W'(NUM_TAPS)) |-> (en == clkA));

endmodule

// File: rtl/pwm_cg_datapath.sv
module pwm_cg_datapath
  import pwm_cg_pkg::*;
#(
  parameter int NUM_TAPS = 11,
  parameter int DIV_W    = 8,
  parameter int SEL_W    = 4,
  parameter int NUM_CH   = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_DIV-1:0][SEL_W-1:0]   preCfg,
  input  logic [NUM_DIV-1:0][DIV_W-1:0]   divCfg,
  input  cgStrobes_t                      stb,
  input  logic [NUM_CH*SEL_W-1:0]         chSel,
  output logic [NUM_TAPS-1:0]             tapEn,
  output logic [NUM_DIV-1:0]              divEn,
  output logic [NUM_CH-1:0]               chEn
);

  localparam int CNT_W = NUM_TAPS - 1;

  logic [CNT_W-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (rst) preCnt <= '0;
    else     preCnt <= preCnt + CNT_W'(1);
  end

  assign tapEn[0] = !rst;
  for (genvar k = 1; k < NUM_TAPS; k++) begin : gTap
    assign tapEn[k] = !rst && (preCnt[k-1:0] == '0);

    assert_tap_nested_R1: assert property (@(posedge clk) disable iff (rst)
      tapEn[k] |-> tapEn[k-1]);
  end

  for (genvar d = 0; d < NUM_DIV; d++) begin : gDiv
    pwm_cg_lindiv #(
      .NUM_TAPS(NUM_TAPS),
      .DIV_W   (DIV_W),
      .SEL_W   (SEL_W)
    ) lindiv_i (
      .clk    (clk),
      .rst    (rst),
      .tapVec (tapEn),
      .pre    (preCfg[d]),
      .div    (divCfg[d]),
      .restart(stb.restart[d]),
      .run    (stb.run[d]),
      .pulse  (divEn[d])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    pwm_cg_chansel #(
      .NUM_TAPS(NUM_TAPS),
      .SEL_W   (SEL_W)
    ) chansel_i (
      .clk   (clk),
      .rst   (rst),
      .sel   (chSel[c*SEL_W +: SEL_W]),
      .tapVec(tapEn),
      .clkA  (divEn[0]),
      .clkB  (divEn[1]),
      .en    (chEn[c])
    );
  end

  assert_half_rate_toggles_R1: assert property (@(posedge clk) disable iff (rst)
    tapEn[1] |=> !tapEn[1]);

  assert_half_rate_returns_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !tapEn[1]) |=> tapEn[1]);

  assert_release_from_zero_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tapEn[NUM_TAPS-1] && preCnt == '0));

  assert_quiet_in_reset_R9: assert property (@(posedge clk)
    rst |-> (tapEn == '0 && divEn == '0 && chEn == '0));

endmodule

// File: rtl/pwm_clock_menu.sv
module pwm_clock_menu
  import pwm_cg_pkg::*;
#(
  parameter int NUM_TAPS = 11,
  parameter int DIV_W    = 8,
  parameter int NUM_CH   = 4,
  localparam int SEL_W   = $clog2(NUM_TAPS + NUM_DIV)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SEL_W-1:0]        preA,
  input  logic [DIV_W-1:0]        divA,
  input  logic [SEL_W-1:0]        preB,
  input  logic [DIV_W-1:0]        divB,
  input  logic [NUM_CH*SEL_W-1:0] chSel,
  output logic [NUM_TAPS-1:0]     tapEn,
  output logic                    clkAEn,
  output logic                    clkBEn,
  output logic [NUM_CH-1:0]       chEn
);

  logic [NUM_DIV-1:0][SEL_W-1:0] preCfg;
  logic [NUM_DIV-1:0][DIV_W-1:0] divCfg;
  logic [NUM_DIV-1:0]            divEn;
  cgStrobes_t                    stb;

  assign preCfg = {preB, preA};
  assign divCfg = {divB, divA};
  assign clkAEn = divEn[0];
  assign clkBEn = divEn[1];

  pwm_cg_ctrl #(
    .NUM_TAPS(NUM_TAPS),
    .DIV_W   (DIV_W),
    .SEL_W   (SEL_W)
  ) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .preCfg(preCfg),
    .divCfg(divCfg),
    .stb   (stb)
  );

  pwm_cg_datapath #(
    .NUM_TAPS(NUM_TAPS),
    .DIV_W   (DIV_W),
    .SEL_W   (SEL_W),
    .NUM_CH  (NUM_CH)
  ) dp_i (
    .clk   (clk),
    .rst   (rst),
    .preCfg(preCfg),
    .divCfg(divCfg),
    .stb   (stb),
    .chSel (chSel),
    .tapEn (tapEn),
    .divEn (divEn),
    .chEn  (chEn)
  );

  assert_invalid_pre_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(preA) >= NUM_TAPS) |-> !clkAEn);

  assert_div_on_tap_R4: assert property (@(posedge clk) disable iff (rst)
    clkBEn |-> (int'(preB) < NUM_TAPS && tapEn[preB]));

endmodule

// File: tb/pwm_clock_menu_tb_top.sv
`timescale 1ns/1ps
module pwm_clock_menu_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  preA = '0, preB = '0;
  logic [7:0]  divA = '0, divB = '0;
  logic [15:0] chSel = '0;
  logic [10:0] tapEn;
  logic        clkAEn, clkBEn;
  logic [3:0]  chEn;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // model state
  int  t;
  int  mCnt [2];
  int  mPre [2];
  int  mDiv [2];
  int  pPre [2];
  int  pDiv [2];

  always #10 clk = ~clk;

  pwm_clock_menu dut_i (
    .clk(clk), .rst(rst), .preA(preA), .divA(divA), .preB(preB), .divB(divB),
    .chSel(chSel), .tapEn(tapEn), .clkAEn(clkAEn), .clkBEn(clkBEn), .chEn(chEn)
  );

  function automatic bit tapAt(int k, int tc);
    return (tc % (1 << k)) == 0;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0d", req, act, exp, t);
    end
  endtask

  // one cycle of the model and comparison against the ports
  task automatic stepCheck();
    logic [10:0] expTap;
    logic [1:0]  expDiv;
    logic [3:0]  expCh;
    expTap = '0;
    for (int k = 0; k < 11; k++) expTap[k] = tapAt(k, t);
    for (int d = 0; d < 2; d++) begin
      expDiv[d] = 1'b0;
      if (mPre[d] != pPre[d] || mDiv[d] != pDiv[d] || mDiv[d] == 0 || mPre[d] > 10) begin
        mCnt[d] = 0;   // R7 restart, R5 off, R6 no input
      end else if (tapAt(mPre[d], t)) begin
        mCnt[d]++;
        if (mCnt[d] == mDiv[d]) begin
          expDiv[d] = 1'b1;
          mCnt[d] = 0;
        end
      end
      pPre[d] = mPre[d];
      pDiv[d] = mDiv[d];
    end
    for (int c = 0; c < 4; c++) begin
      int s;
      s = int'(chSel[c*4 +: 4]);
      if (s <= 10)      expCh[c] = expTap[s];
      else if (s == 11) expCh[c] = expDiv[0];
      else if (s == 12) expCh[c] = expDiv[1];
      else              expCh[c] = 1'b0;
    end
    check("R1 taps", int'(tapEn), int'(expTap));
    check((mDiv[0] == 0) ? "R5 clkA off" : (mPre[0] > 10) ? "R6 clkA no tap" : "R2/R7 clkA",
          int'(clkAEn), int'(expDiv[0]));
    check((mDiv[1] == 0) ? "R5 clkB off" : (mPre[1] > 10) ? "R6 clkB no tap" : "R3/R4 clkB",
          int'(clkBEn), int'(expDiv[1]));
    check("R8 channels", int'(chEn), int'(expCh));
  endtask

  task automatic runCase(int pa, int na, int pb, int nb, int sweepIdx, int len,
                         int changeAt, int newNa, int newPb);
    @(negedge clk);
    rst  = 1'b1;
    preA = 4'(pa); divA = 8'(na);
    preB = 4'(pb); divB = 8'(nb);
    for (int c = 0; c < 4; c++) chSel[c*4 +: 4] = 4'((sweepIdx + 4 * c) % 16);
    @(negedge clk);
    @(negedge clk);
    // R9: all outputs low while reset is held
    t = -1;
    check("R9 reset quiet", int'({tapEn, clkAEn, clkBEn, chEn}), 0);
    rst = 1'b0;
    t = 0;
    mPre[0] = pa; mDiv[0] = na; mPre[1] = pb; mDiv[1] = nb;
    for (int d = 0; d < 2; d++) begin
      mCnt[d] = 0; pPre[d] = mPre[d]; pDiv[d] = mDiv[d];
    end
    for (int i = 0; i < len; i++) begin
      if (i == changeAt) begin
        divA = 8'(newNa); mDiv[0] = newNa;
        preB = 4'(newPb); mPre[1] = newPb;
      end
      #1;
      stepCheck();
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    int idx;
    int nList [3];
    nList = '{0, 1, 3};
    idx = 0;
    // sweep every tap on divider A, invalid and valid taps on divider B
    for (int p = 0; p < 11; p++) begin
      for (int j = 0; j < 3; j++) begin
        int pb, nb, big, len;
        pb  = (p + 3) % 12;
        nb  = 2 + (p % 3);
        big = p;
        if (pb < 11 && pb > big) big = pb;
        len = (1 << big) * 6 + 16;
        runCase(p, nList[j], pb, nb, idx, len, len / 2, nList[j] + 1, (pb + 1) % 11);
        idx++;
      end
    end
    // R2: largest ratio on the fastest tap
    runCase(0, 255, 15, 7, 11, 600, -1, 0, 0);
    // R6: invalid selects on both dividers, R8: unused channel codes
    for (int p = 11; p < 16; p++) begin
      runCase(p, 2, 26 - p, 1, 13 + (p % 3), 40, -1, 0, 0);
    end
    // R7: change of divider B select only, with A fixed
    runCase(1, 2, 0, 3, 12, 200, 37, 2, 2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule